// File: doc/BRIEF.md
# DRAM Low-Power Clock-Stop Sequencer

This block is the control state machine inside a DRAM memory controller that moves the memory device between normal operation, power-down and self-refresh, and that gates the memory clock. Software sets a mode-select bit, a low-power enable bit and a clock-stop enable bit. The sequencer drains outstanding traffic and pending refreshes, drops CKE (with a self-refresh command when self-refresh is chosen), and in self-refresh alone it may shut the memory clock and the DLL. When the clock is off it raises a status flag that tells the system that gating the upstream clocks is safe.

An access from the arbiter that arrives while the clock is stopped needs no help from software. The sequencer re-enables the DLL, waits for lock, restarts the memory clock, raises CKE, waits a programmed exit delay and only then grants the access. If the low-power bits are still set once the access has been served, it goes back to self-refresh. A self-clearing PHY reset bit is also kept here. The DLL is modelled as a lock counter. The PHY finishing its reset is modelled as a done pulse.

Top module: `dram_lp_seq`

## Requirements
- R1: While reset is active and right after it is released, cke=1, mclk_en=1, dll_en=1, upclk_gate_ok=0 and phy_rst_bit=0. No acc_ack is given until dll_locked has asserted.
- R2: With lp_en=1, mode_pd=0 selects self-refresh: sr_cmd pulses once in the same cycle in which cke first goes low. With mode_pd=1 the same enable selects power-down: cke goes low and sr_cmd never pulses.
- R3: CKE does not drop while acc_busy=1 or rfsh_backlog is nonzero. While backlog remains and acc_busy=0, rfsh_cmd pulses one cycle at a time, never in two consecutive cycles, and exactly once per backlogged refresh.
- R4: mclk_en goes low only while cke is low in self-refresh. In power-down, clkstop_en has no effect and mclk_en stays 1.
- R5: Once the device is in self-refresh with clkstop_en=1 and no request pending, mclk_en goes low within fewer than 150 cycles (STOP_CYC+2 with the default parameters).
- R6: An access that arrives with the clock stopped raises dll_en first. mclk_en rises only when dll_locked is high, and cke rises only after that. acc_ack comes last. Afterwards the block returns to self-refresh with the clock stopped if both enables are still set.
- R7: upclk_gate_ok is 1 only in self-refresh with the memory clock and DLL stopped. It is never 1 in power-down.
- R8: A pulse on phy_rst_wr sets phy_rst_bit. The bit stays set until a phy_rst_done pulse and then returns to 0 without any write.
- R9: Self-refresh is kept while either clkstop_en or lp_en is set. Clearing clkstop_en restarts the clock with cke still low. Only when both are clear does cke rise.
- R10: After cke rises on an exit, at least XSR_CYC cycles pass with cke high before the first acc_ack.
- R11: Requests that arrive while the block is draining, entering or leaving a low-power state see acc_ack=0. They are held and granted once the block is active. acc_ack is only ever given to a request that is present.
- R12: dll_locked asserts exactly LOCK_CYC cycles after dll_en rises, and it is low whenever dll_en was low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode_pd | input | 1 | Mode select: 1 power-down, 0 self-refresh |
| cfg_lp_en | input | 1 | Low-power enable |
| cfg_clkstop_en | input | 1 | Allow memory clock shut-off in self-refresh |
| phy_rst_wr | input | 1 | Write-one strobe to the PHY reset bit |
| phy_rst_done | input | 1 | PHY reports its reset finished |
| phy_rst_bit | output | 1 | PHY reset bit, self-clearing |
| acc_req | input | 1 | Access request from the arbiter, held until acked |
| acc_ack | output | 1 | Access granted this cycle |
| acc_busy | input | 1 | Accesses still outstanding |
| rfsh_backlog | input | BL_W | Number of backlogged refreshes |
| rfsh_cmd | output | 1 | Issue one refresh |
| sr_cmd | output | 1 | Self-refresh entry command |
| cke | output | 1 | Clock enable to the device |
| mclk_en | output | 1 | Memory clock gate enable |
| dll_en | output | 1 | DLL enable |
| dll_locked | output | 1 | DLL lock indication |
| upclk_gate_ok | output | 1 | Safe to gate upstream clocks |

## Verification
On every cycle the assertions check the safety rules: the clock is off only with CKE low, the gate-safe flag implies that clock, DLL and CKE are all off, the clock restarts only with lock, the shut-off is bounded, refresh pulses are spaced, CKE stays high for the exit delay before any grant, and the PHY bit changes only on its strobes. Only the bench scenarios can show the orderings and counts. These are the mode decode between power-down and self-refresh, the exact number of refresh pulses per backlog, the full wake order on an access with the clock stopped, the return to self-refresh afterwards, the two-step exit, and requests held during transitions.

// File: rtl/lp_seq_pkg.sv
// Shared state encoding for the low-power sequencer.
// Assumes: one-hot is not required; consumers decode by enum name only.
package lp_seq_pkg;
    typedef enum logic [3:0] {
        ST_INIT,
        ST_ACTIVE,
        ST_DRAIN,
        ST_ENTER,
        ST_PWRDN,
        ST_SELFREF,
        ST_STOPPING,
        ST_CLKOFF,
        ST_WAKE,
        ST_EXIT
    } lp_state_e;
endpackage

// File: rtl/lp_dll_model.sv
// Behavioural DLL: lock asserts LOCK_CYC cycles after enable rises.
// Assumes: enable low clears lock and counter on the next edge.
module lp_dll_model #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dll_en,
    output logic dll_locked
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [LW-1:0] cnt;

    // Count enabled cycles and flag lock when the count expires.
    always_ff @(posedge clk) begin
        if (!rst_n || !dll_en) begin
            cnt        <= '0;
            dll_locked <= 1'b0;
        end else if (!dll_locked) begin
            if (cnt == LW'(LOCK_CYC - 1)) begin
                dll_locked <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lp_countdown.sv
// Loadable down-counter; done is high while the count is zero.
// Assumes: load wins over decrement; the owner ignores done outside its state.
module lp_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lp_phy_rst_bit.sv
// Self-clearing PHY reset control bit.
// Assumes: a write strobe and a done pulse never arrive in the same cycle;
// if they do, the write wins.
module lp_phy_rst_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic done,
    output logic rst_bit
);
    // Set on write-one, clear when the PHY reports completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_bit <= 1'b0;
        end else if (wr) begin
            rst_bit <= 1'b1;
        end else if (done) begin
            rst_bit <= 1'b0;
        end
    end
endmodule

// File: rtl/lp_seq_fsm.sv
// Main low-power state machine: drain, entry, clock stop, wake and exit.
// Assumes: the arbiter holds acc_req until acc_ack; the backlog source
// decrements once per rfsh_cmd pulse; timers are loaded by this module.
module lp_seq_fsm
    import lp_seq_pkg::*;
#(
    parameter int BL_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_mode_pd,
    input  logic            cfg_lp_en,
    input  logic            cfg_clkstop_en,
    input  logic            acc_req,
    input  logic            acc_busy,
    input  logic [BL_W-1:0] rfsh_backlog,
    input  logic            dll_locked,
    input  logic            stop_done,
    input  logic            exit_done,
    output logic            stop_load,
    output logic            exit_load,
    output logic            rfsh_cmd,
    output logic            sr_cmd,
    output logic            cke,
    output logic            mclk_en,
    output logic            dll_en,
    output logic            acc_ack,
    output logic            gate_ok
);
    lp_state_e state, nxt;
    logic      mode_sr;
    logic      rfsh_q;

    // Next-state decision for every low-power transition.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_INIT:     if (dll_locked) nxt = ST_ACTIVE;
            ST_ACTIVE:   if (!acc_req && cfg_lp_en) nxt = ST_DRAIN;
            ST_DRAIN: begin
                if (!cfg_lp_en) begin
                    nxt = ST_ACTIVE;
                end else if (!acc_busy && (rfsh_backlog == '0)) begin
                    nxt = ST_ENTER;
                end
            end
            ST_ENTER:    nxt = mode_sr ? ST_SELFREF : ST_PWRDN;
            ST_PWRDN:    if (acc_req || !cfg_lp_en || !cfg_mode_pd) nxt = ST_EXIT;
            ST_SELFREF: begin
                if (acc_req || (!cfg_lp_en && !cfg_clkstop_en)) begin
                    nxt = ST_EXIT;
                end else if (cfg_clkstop_en) begin
                    nxt = ST_STOPPING;
                end
            end
            ST_STOPPING: begin
                if (acc_req || !cfg_clkstop_en) begin
                    nxt = ST_SELFREF;
                end else if (stop_done) begin
                    nxt = ST_CLKOFF;
                end
            end
            ST_CLKOFF:   if (acc_req || !cfg_clkstop_en) nxt = ST_WAKE;
            ST_WAKE:     if (dll_locked) nxt = ST_SELFREF;
            ST_EXIT:     if (exit_done) nxt = ST_ACTIVE;
            default:     nxt = ST_INIT;
        endcase
    end

    // State, latched mode and refresh spacing registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_INIT;
            mode_sr <= 1'b0;
            rfsh_q  <= 1'b0;
        end else begin
            state  <= nxt;
            rfsh_q <= rfsh_cmd;
            if (state == ST_ACTIVE && nxt == ST_DRAIN) begin
                mode_sr <= !cfg_mode_pd;
            end
        end
    end

    // Output decode from the current state.
    always_comb begin
        stop_load = (state == ST_SELFREF) && (nxt == ST_STOPPING);
        exit_load = (state != ST_EXIT) && (nxt == ST_EXIT);
        rfsh_cmd  = (state == ST_DRAIN) && cfg_lp_en && !acc_busy &&
                    (rfsh_backlog != '0) && !rfsh_q;
        sr_cmd    = (state == ST_ENTER) && mode_sr;
        cke       = (state == ST_INIT) || (state == ST_ACTIVE) ||
                    (state == ST_DRAIN) || (state == ST_EXIT);
        mclk_en   = (state != ST_CLKOFF) && (state != ST_WAKE);
        dll_en    = (state != ST_CLKOFF);
        acc_ack   = (state == ST_ACTIVE) && acc_req;
        gate_ok   = (state == ST_CLKOFF);
    end
endmodule

// File: rtl/dram_lp_seq.sv
// Top of the DRAM low-power clock-stop sequencer.
// Assumes: all inputs are synchronous to clk; STOP_CYC + 2 stays under the
// 150-cycle shut-off bound that software relies on.
module dram_lp_seq #(
    parameter int BL_W     = 4,
    parameter int LOCK_CYC = 16,
    parameter int STOP_CYC = 8,
    parameter int XSR_CYC  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_mode_pd,
    input  logic            cfg_lp_en,
    input  logic            cfg_clkstop_en,
    input  logic            phy_rst_wr,
    input  logic            phy_rst_done,
    output logic            phy_rst_bit,
    input  logic            acc_req,
    output logic            acc_ack,
    input  logic            acc_busy,
    input  logic [BL_W-1:0] rfsh_backlog,
    output logic            rfsh_cmd,
    output logic            sr_cmd,
    output logic            cke,
    output logic            mclk_en,
    output logic            dll_en,
    output logic            dll_locked,
    output logic            upclk_gate_ok
);
    localparam int TMAX = (STOP_CYC > XSR_CYC) ? STOP_CYC : XSR_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    logic stop_load, exit_load, stop_done, exit_done;

    lp_seq_fsm #(.BL_W(BL_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_mode_pd    (cfg_mode_pd),
        .cfg_lp_en      (cfg_lp_en),
        .cfg_clkstop_en (cfg_clkstop_en),
        .acc_req        (acc_req),
        .acc_busy       (acc_busy),
        .rfsh_backlog   (rfsh_backlog),
        .dll_locked     (dll_locked),
        .stop_done      (stop_done),
        .exit_done      (exit_done),
        .stop_load      (stop_load),
        .exit_load      (exit_load),
        .rfsh_cmd       (rfsh_cmd),
        .sr_cmd         (sr_cmd),
        .cke            (cke),
        .mclk_en        (mclk_en),
        .dll_en         (dll_en),
        .acc_ack        (acc_ack),
        .gate_ok        (upclk_gate_ok)
    );

    lp_dll_model #(.LOCK_CYC(LOCK_CYC)) u_dll (
        .clk        (clk),
        .rst_n      (rst_n),
        .dll_en     (dll_en),
        .dll_locked (dll_locked)
    );

    lp_countdown #(.W(TW)) u_stop_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (stop_load),
        .load_val (TW'(STOP_CYC)),
        .done     (stop_done)
    );

    lp_countdown #(.W(TW)) u_exit_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (exit_load),
        .load_val (TW'(XSR_CYC)),
        .done     (exit_done)
    );

    lp_phy_rst_bit u_phy_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (phy_rst_wr),
        .done    (phy_rst_done),
        .rst_bit (phy_rst_bit)
    );
endmodule

// File: rtl/dram_lp_seq_chk.sv
// Protocol checker for dram_lp_seq, attached by bind below.
// Assumes: the bench environment keeps acc_req held until acc_ack.
module dram_lp_seq_chk #(
    parameter int BL_W       = 4,
    parameter int XSR_CYC    = 10,
    parameter int STOP_LIMIT = 150
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_mode_pd,
    input logic            cfg_lp_en,
    input logic            cfg_clkstop_en,
    input logic            phy_rst_wr,
    input logic            phy_rst_done,
    input logic            phy_rst_bit,
    input logic            acc_req,
    input logic            acc_ack,
    input logic            acc_busy,
    input logic [BL_W-1:0] rfsh_backlog,
    input logic            rfsh_cmd,
    input logic            sr_cmd,
    input logic            cke,
    input logic            mclk_en,
    input logic            dll_en,
    input logic            dll_locked,
    input logic            upclk_gate_ok
);
    logic [7:0] stop_cnt;
    logic [7:0] hi_cnt;
    logic       armed;

    // Cycles spent in self-refresh with clock-stop requested but clock running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_cnt <= '0;
        end else if (!cke && cfg_clkstop_en && !cfg_mode_pd && cfg_lp_en &&
                     !acc_req && mclk_en) begin
            if (stop_cnt != 8'hFF) stop_cnt <= stop_cnt + 1'b1;
        end else begin
            stop_cnt <= '0;
        end
    end

    // Cycles of cke high since it last rose, armed after the first low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            armed  <= 1'b0;
        end else if (!cke) begin
            hi_cnt <= '0;
            armed  <= 1'b1;
        end else if (hi_cnt != 8'hFF) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_sr_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sr_cmd |-> (!cke && $past(cke)));
    p_drain_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sr_cmd |-> $past(!acc_busy && (rfsh_backlog == '0)));
    p_rfsh_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_cmd |-> (!acc_busy && (rfsh_backlog != '0)));
    p_rfsh_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_cmd |=> !rfsh_cmd);
    p_clk_off_cke_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_en |-> !cke);
    p_stop_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cnt < 8'(STOP_LIMIT));
    p_wake_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk_en) |-> dll_locked);
    p_gate_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upclk_gate_ok |-> (!mclk_en && !dll_en && !cke));
    p_phy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_bit) |-> $past(phy_rst_wr));
    p_phy_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst_bit) |-> $past(phy_rst_done));
    p_exit_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ack && armed) |-> (hi_cnt >= 8'(XSR_CYC)));
    p_ack_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |-> (acc_req && cke && mclk_en));
    p_lock_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dll_locked |-> $past(dll_en));
endmodule

bind dram_lp_seq dram_lp_seq_chk #(
    .BL_W    (BL_W),
    .XSR_CYC (XSR_CYC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_mode_pd    (cfg_mode_pd),
    .cfg_lp_en      (cfg_lp_en),
    .cfg_clkstop_en (cfg_clkstop_en),
    .phy_rst_wr     (phy_rst_wr),
    .phy_rst_done   (phy_rst_done),
    .phy_rst_bit    (phy_rst_bit),
    .acc_req        (acc_req),
    .acc_ack        (acc_ack),
    .acc_busy       (acc_busy),
    .rfsh_backlog   (rfsh_backlog),
    .rfsh_cmd       (rfsh_cmd),
    .sr_cmd         (sr_cmd),
    .cke            (cke),
    .mclk_en        (mclk_en),
    .dll_en         (dll_en),
    .dll_locked     (dll_locked),
    .upclk_gate_ok  (upclk_gate_ok)
);

// File: tb/dram_lp_seq_bench.sv
`timescale 1ns/1ps
module dram_lp_seq_bench;
    localparam int BL_W = 4;
    localparam int LOCK = 16;
    localparam int STOP = 8;
    localparam int XSR  = 10;

    typedef struct packed {
        logic       pd;
        logic       cs;
        logic [5:0] busy;
        logic [3:0] bl;
        logic       e_sr;
        logic       e_off;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b0, 6'd2, 4'd0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 6'd3, 4'd2, 1'b1, 1'b1},
        '{1'b1, 1'b0, 6'd1, 4'd1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 6'd4, 4'd3, 1'b0, 1'b0},
        '{1'b0, 1'b1, 6'd0, 4'd5, 1'b1, 1'b1},
        '{1'b1, 1'b1, 6'd0, 4'd0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mode_pd = 1'b0, cfg_lp_en = 1'b0, cfg_clkstop_en = 1'b0;
    logic phy_rst_wr = 1'b0, phy_rst_done = 1'b0, phy_rst_bit;
    logic acc_req = 1'b0, acc_ack, acc_busy = 1'b0;
    logic [BL_W-1:0] rfsh_backlog = '0;
    logic rfsh_cmd, sr_cmd, cke, mclk_en, dll_en, dll_locked, upclk_gate_ok;

    logic bl_set = 1'b0, mon_clr = 1'b0;
    logic [BL_W-1:0] bl_val = '0;
    int sr_cnt = 0, rf_cnt = 0;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    dram_lp_seq #(.BL_W(BL_W), .LOCK_CYC(LOCK), .STOP_CYC(STOP), .XSR_CYC(XSR)) u_dram_lp_seq (
        .clk(clk), .rst_n(rst_n), .cfg_mode_pd(cfg_mode_pd), .cfg_lp_en(cfg_lp_en),
        .cfg_clkstop_en(cfg_clkstop_en), .phy_rst_wr(phy_rst_wr), .phy_rst_done(phy_rst_done),
        .phy_rst_bit(phy_rst_bit), .acc_req(acc_req), .acc_ack(acc_ack), .acc_busy(acc_busy),
        .rfsh_backlog(rfsh_backlog), .rfsh_cmd(rfsh_cmd), .sr_cmd(sr_cmd), .cke(cke),
        .mclk_en(mclk_en), .dll_en(dll_en), .dll_locked(dll_locked), .upclk_gate_ok(upclk_gate_ok)
    );

    // Refresh backlog source: loaded by the test, decremented per refresh pulse.
    always @(posedge clk) begin
        if (bl_set) rfsh_backlog <= bl_val;
        else if (rfsh_cmd && rfsh_backlog != '0) rfsh_backlog <= rfsh_backlog - 1'b1;
    end

    // Pulse counters for self-refresh commands and refreshes.
    always @(posedge clk) begin
        if (mon_clr) begin
            sr_cnt <= 0;
            rf_cnt <= 0;
        end else begin
            if (sr_cmd) sr_cnt <= sr_cnt + 1;
            if (rfsh_cmd) rf_cnt <= rf_cnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t_en, t_lk, t_mc, t_ck, t_ak, seen;
        cyc(4);
        chk("R1 cke in reset", int'(cke), 1);
        chk("R1 mclk_en in reset", int'(mclk_en), 1);
        chk("R1 dll_en in reset", int'(dll_en), 1);
        rst_n = 1'b1;
        chk("R1 gate_ok after reset", int'(upclk_gate_ok), 0);
        chk("R1 phy bit after reset", int'(phy_rst_bit), 0);
        acc_req = 1'b1;
        cyc(LOCK - 1);
        chk("R12 not locked early", int'(dll_locked), 0);
        chk("R1 no ack before lock", int'(acc_ack), 0);
        cyc(1);
        chk("R12 locked after LOCK cycles", int'(dll_locked), 1);
        chk("R1 no ack at lock", int'(acc_ack), 0);
        cyc(1);
        chk("R1 ack once active", int'(acc_ack), 1);
        acc_req = 1'b0;
        cyc(2);

        // Table walk: mode decode, drain, refresh count, clock stop, exit.
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            v = VEC[i];
            bl_val = v.bl;
            bl_set = 1'b1;
            mon_clr = 1'b1;
            acc_busy = (v.busy != 0);
            cfg_mode_pd = v.pd;
            cfg_clkstop_en = v.cs;
            cfg_lp_en = 1'b1;
            cyc(1);
            bl_set = 1'b0;
            mon_clr = 1'b0;
            if (v.busy > 1) begin
                cyc(int'(v.busy) - 1);
                chk("R3 cke held while busy", int'(cke), 1);
                chk("R3 no sr_cmd while busy", sr_cnt, 0);
            end
            acc_busy = 1'b0;
            cyc(60);
            chk("R2 sr_cmd count", sr_cnt, int'(v.e_sr));
            chk("R2 cke low in low power", int'(cke), 0);
            chk("R3 refresh pulses", rf_cnt, int'(v.bl));
            chk("R4 R5 mclk_en state", int'(mclk_en), int'(!v.e_off));
            chk("R7 gate_ok state", int'(upclk_gate_ok), int'(v.e_off));
            cfg_clkstop_en = 1'b0;
            cyc(40);
            chk("R9 clock back, cke still low", int'(mclk_en) * 2 + int'(cke), 2);
            cfg_lp_en = 1'b0;
            cyc(30);
            chk("R9 cke high after both cleared", int'(cke), 1);
        end

        // Wake order on an access with the clock stopped.
        cfg_mode_pd = 1'b0;
        cfg_clkstop_en = 1'b1;
        cfg_lp_en = 1'b1;
        cyc(40);
        chk("R7 gate_ok with clock stopped", int'(upclk_gate_ok), 1);
        t_en = -1; t_lk = -1; t_mc = -1; t_ck = -1; t_ak = -1;
        acc_req = 1'b1;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (dll_en && t_en < 0) t_en = t;
            if (dll_locked && t_lk < 0) t_lk = t;
            if (mclk_en && t_mc < 0) t_mc = t;
            if (cke && t_ck < 0) t_ck = t;
            if (acc_ack) begin
                t_ak = t;
                break;
            end
        end
        acc_req = 1'b0;
        chk("R6 access granted", int'(t_ak >= 0), 1);
        chk("R12 lock delay", t_lk - t_en, LOCK);
        chk("R6 clock after lock", int'(t_mc >= t_lk && t_lk > t_en), 1);
        chk("R6 cke after clock", int'(t_ck > t_mc), 1);
        chk("R10 exit delay before ack", int'(t_ak - t_ck >= XSR), 1);
        cyc(40);
        chk("R6 clock stopped again", int'(mclk_en), 0);

        // Exit order: lp_en alone does not leave self-refresh.
        cfg_lp_en = 1'b0;
        cyc(30);
        chk("R9 cke low while clkstop set", int'(cke), 0);
        chk("R9 clock off while clkstop set", int'(mclk_en), 0);
        cfg_clkstop_en = 1'b0;
        cyc(60);
        chk("R9 cke high after clkstop cleared", int'(cke), 1);
        chk("R9 clock on after exit", int'(mclk_en), 1);

        // Requests held during drain and entry.
        cfg_lp_en = 1'b1;
        acc_busy = 1'b1;
        cyc(2);
        acc_req = 1'b1;
        seen = 0;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            if (acc_ack) seen = 1;
        end
        chk("R11 no ack while draining", seen, 0);
        acc_busy = 1'b0;
        seen = 0;
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (acc_ack) begin
                seen = 1;
                break;
            end
        end
        acc_req = 1'b0;
        chk("R11 held request granted", seen, 1);
        cfg_lp_en = 1'b0;
        cyc(40);
        chk("R11 back to active", int'(cke), 1);

        // PHY reset bit.
        phy_rst_wr = 1'b1;
        cyc(1);
        phy_rst_wr = 1'b0;
        chk("R8 bit set by write", int'(phy_rst_bit), 1);
        cyc(3);
        chk("R8 bit held until done", int'(phy_rst_bit), 1);
        phy_rst_done = 1'b1;
        cyc(1);
        phy_rst_done = 1'b0;
        chk("R8 bit self-cleared", int'(phy_rst_bit), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule